// File: doc/BRIEF.md
# Memory-Backed Command Queue Controller

This block keeps a command queue for a graphics-style engine in a region of linear frame memory. The host writes command words through an address window. The block stores each word in memory relative to a programmable base and counts how many words are waiting. A downstream consumer pulls the words back out in order through a request/valid handshake, and the block advances a read pointer as it goes. Software can write the read pointer and the pending-word count directly, so the queue can be rewound, skipped or flushed.

The same host write port also carries ordinary register writes bound for the rest of the engine. While queue mode is on, only registers flagged as write-through in a parameter mask are passed on. All other ordinary writes are discarded. A status word reports a busy field while the queue is on and holds pending words. The frame memory sits outside the block and is reached through a simple synchronous RAM port with separate read and write sides and a one-cycle read latency.

Top module: `cmdq_mem_ctrl`

## Requirements
- R1: After reset the pending count, read pointer and base are zero, queue mode and store mode are off, and `status_o`, `fetch_valid_o`, `mem_we_o` and `mem_re_o` are all low.
- R2: A host write with address bit 19 set, while queue mode and store mode are both on, writes `hw_data_i` to memory byte address `base + (hw_addr_i[15:0] << 2)`, truncated to `MEM_AW` bits, in the same cycle. It also adds one to the pending count and is not forwarded as a register write.
- R3: A write to register index 0x78 sets the base to `hw_data_i[9:0] << 12`.
- R4: A write to register index 0x79 loads all 32 bits of `hw_data_i` into the read pointer. A write to index 0x7A loads `hw_data_i[15:0]` into the pending count.
- R5: An accepted fetch drives a memory read at the low `MEM_AW` bits of the read pointer in the request cycle. It raises `fetch_valid_o` with the read word on the next cycle, adds 4 to the read pointer and subtracts one from the pending count.
- R6: A fetch request while the pending count is zero issues no memory read and leaves `fetch_valid_o` low. The count never wraps below zero.
- R7: A command push and an accepted fetch in the same cycle leave the pending count unchanged.
- R8: The pending count saturates at 0xFFFF: a push at that value leaves it at 0xFFFF.
- R9: A register write to the read pointer or the pending count in the same cycle as an accepted fetch takes the written value and overrides the fetch's own update.
- R10: Ordinary register writes (any index other than 0x41, 0x78, 0x79, 0x7A and not a command push) are forwarded in the same cycle on `reg_wr_*` when queue mode is off. When it is on, they are forwarded only if their index bit is set in `WT_MASK` (default indices 0x20, 0x21, 0x60) and are dropped otherwise.
- R11: `status_o` equals 0x380 (bits 9:7 set) when queue mode is on and the pending count is nonzero, and equals 0 otherwise.
- R12: A write to register index 0x41 sets queue mode from data bit 8 and store mode from data bit 9. With queue mode on and store mode off, a write with address bit 19 set is treated as an ordinary register write indexed by address bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_valid_i | input | 1 | Host write strobe |
| hw_addr_i | input | ADDR_W | Host word address; bit 19 selects the command window, bits 7:0 the register index |
| hw_data_i | input | 32 | Host write data |
| reg_wr_valid_o | output | 1 | Forwarded ordinary register write |
| reg_wr_addr_o | output | ADDR_W | Forwarded write address |
| reg_wr_data_o | output | 32 | Forwarded write data |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_waddr_o | output | MEM_AW | Frame memory write byte address |
| mem_wdata_o | output | 32 | Frame memory write data |
| mem_re_o | output | 1 | Frame memory read enable |
| mem_raddr_o | output | MEM_AW | Frame memory read byte address |
| mem_rdata_i | input | 32 | Frame memory read data, one cycle after `mem_re_o` |
| fetch_req_i | input | 1 | Consumer word request |
| fetch_valid_o | output | 1 | Consumer word valid |
| fetch_data_o | output | 32 | Consumer word |
| status_o | output | 32 | Status word; bits 9:7 are the busy field |

## Verification
The bench targets the count boundaries. A fetch on an empty queue would wrap the count to 0xFFFF if the block let it underflow, and the extra valid words on later fetches show that. A push at 0xFFFF would wrap to zero and clear the busy field. A push and a fetch in the same cycle would leave one word too many or too few, so the bench counts valid responses afterwards. The bench also places register loads of the pointer and count in the same cycle as a fetch. If the fetch won, the next read address would be off by 4, or the number of words drained would be wrong. Finally, the bench checks the address truncation on a push near the top of memory, and write gating in each of the three mode combinations.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int REG_IDX_W = 8;
  localparam int NUM_REGS = 1 << REG_IDX_W;
  localparam int CMD_SEL_BIT = 19;
  localparam int OFF_W = 16;
  localparam int MODE_EN_BIT = 8;
  localparam int MODE_STORE_BIT = 9;

  localparam logic [REG_IDX_W-1:0] REG_MODE   = 8'h41;
  localparam logic [REG_IDX_W-1:0] REG_QBASE  = 8'h78;
  localparam logic [REG_IDX_W-1:0] REG_QRDPTR = 8'h79;
  localparam logic [REG_IDX_W-1:0] REG_QDEPTH = 8'h7A;

  typedef struct packed {
    logic push;
    logic ld_base;
    logic ld_rdptr;
    logic ld_depth;
    logic ld_mode;
    logic fwd;
  } host_op_t;
endpackage

// File: rtl/cmdq_host_decode.sv
module cmdq_host_decode
  import cmdq_pkg::*;
#(
  parameter logic [NUM_REGS-1:0] WT_MASK = '0
) (
  input  logic                 valid_i,
  input  logic                 cmd_sel_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic                 en_i,
  input  logic                 store_i,
  output host_op_t             op_o
);
  logic is_cmd, is_ctrl, ordinary;

  always_comb begin
    is_cmd   = valid_i && cmd_sel_i && en_i && store_i;
    ordinary = valid_i && !is_cmd;
    is_ctrl  = (idx_i == REG_MODE) || (idx_i == REG_QBASE) ||
               (idx_i == REG_QRDPTR) || (idx_i == REG_QDEPTH);
    op_o.push     = is_cmd;
    op_o.ld_mode  = ordinary && (idx_i == REG_MODE);
    op_o.ld_base  = ordinary && (idx_i == REG_QBASE);
    op_o.ld_rdptr = ordinary && (idx_i == REG_QRDPTR);
    op_o.ld_depth = ordinary && (idx_i == REG_QDEPTH);
    // queue control registers are always accepted and never forwarded
    op_o.fwd      = ordinary && !is_ctrl && (!en_i || WT_MASK[idx_i]);
  end
endmodule

// File: rtl/cmdq_queue_state.sv
module cmdq_queue_state
  import cmdq_pkg::*;
#(
  parameter int MEM_AW  = 22,
  parameter int DEPTH_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  host_op_t           op_i,
  input  logic [31:0]        wdata_i,
  input  logic               pop_i,
  output logic [MEM_AW-1:0]  base_o,
  output logic [31:0]        rdptr_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               en_o,
  output logic               store_o
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
  localparam int BASE_SHIFT = 12;
  localparam int BASE_W = 10;

  logic [BASE_W+BASE_SHIFT-1:0] base_full;
  logic [DEPTH_W-1:0] depth_d;

  assign base_full = {wdata_i[BASE_W-1:0], {BASE_SHIFT{1'b0}}};

  always_comb begin
    depth_d = depth_o;
    if (op_i.ld_depth) begin
      depth_d = wdata_i[DEPTH_W-1:0];
    end else begin
      unique case ({op_i.push, pop_i})
        2'b10:   if (depth_o != DEPTH_MAX) depth_d = depth_o + 1'b1;
        2'b01:   if (depth_o != '0) depth_d = depth_o - 1'b1;
        default: depth_d = depth_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      rdptr_o <= '0;
      depth_o <= '0;
      en_o    <= 1'b0;
      store_o <= 1'b0;
    end else begin
      depth_o <= depth_d;
      if (op_i.ld_base) base_o <= MEM_AW'(base_full);
      if (op_i.ld_rdptr) rdptr_o <= wdata_i;
      else if (pop_i) rdptr_o <= rdptr_o + 32'd4;
      if (op_i.ld_mode) begin
        en_o    <= wdata_i[MODE_EN_BIT];
        store_o <= wdata_i[MODE_STORE_BIT];
      end
    end
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == '0 && !op_i.ld_depth && !op_i.push) |=> depth_o == '0);
  // R8
  depth_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == DEPTH_MAX && op_i.push && !pop_i && !op_i.ld_depth) |=> depth_o == DEPTH_MAX);
  // R7
  depth_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.push && pop_i && !op_i.ld_depth) |=> $stable(depth_o));
  // R5
  rdptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !op_i.ld_rdptr) |=> rdptr_o == $past(rdptr_o) + 32'd4);
  // R9
  depth_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.ld_depth |=> depth_o == $past(wdata_i[DEPTH_W-1:0]));
  // R9
  rdptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.ld_rdptr |=> rdptr_o == $past(wdata_i));
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch #(
  parameter int MEM_AW = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              depth_nz_i,
  input  logic [MEM_AW-1:0] rdptr_i,
  input  logic [31:0]       rdata_i,
  output logic              pop_o,
  output logic              re_o,
  output logic [MEM_AW-1:0] raddr_o,
  output logic              valid_o,
  output logic [31:0]       data_o
);
  logic valid_q;

  assign pop_o   = req_i && depth_nz_i;
  assign re_o    = pop_o;
  assign raddr_o = rdptr_i;
  assign valid_o = valid_q;
  assign data_o  = rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= pop_o;
  end

  // R5
  valid_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> valid_o);
endmodule

// File: rtl/cmdq_mem_ctrl.sv
module cmdq_mem_ctrl
  import cmdq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MEM_AW  = 22,
  parameter int DEPTH_W = 16,
  parameter logic [NUM_REGS-1:0] WT_MASK =
    (256'd1 << 8'h20) | (256'd1 << 8'h21) | (256'd1 << 8'h60)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_valid_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic [31:0]       hw_data_i,
  output logic              reg_wr_valid_o,
  output logic [ADDR_W-1:0] reg_wr_addr_o,
  output logic [31:0]       reg_wr_data_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_waddr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_re_o,
  output logic [MEM_AW-1:0] mem_raddr_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              fetch_req_i,
  output logic              fetch_valid_o,
  output logic [31:0]       fetch_data_o,
  output logic [31:0]       status_o
);
  localparam int BUSY_LSB = 7;
  localparam int BUSY_W = 3;

  host_op_t           op;
  logic [MEM_AW-1:0]  base;
  logic [31:0]        rdptr;
  logic [DEPTH_W-1:0] depth;
  logic               en, store, pop, depth_nz, busy;

  cmdq_host_decode #(.WT_MASK(WT_MASK)) u_decode (
    .valid_i  (hw_valid_i),
    .cmd_sel_i(hw_addr_i[CMD_SEL_BIT]),
    .idx_i    (hw_addr_i[REG_IDX_W-1:0]),
    .en_i     (en),
    .store_i  (store),
    .op_o     (op)
  );

  cmdq_queue_state #(.MEM_AW(MEM_AW), .DEPTH_W(DEPTH_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .wdata_i(hw_data_i),
    .pop_i  (pop),
    .base_o (base),
    .rdptr_o(rdptr),
    .depth_o(depth),
    .en_o   (en),
    .store_o(store)
  );

  assign depth_nz = (depth != '0);

  cmdq_fetch #(.MEM_AW(MEM_AW)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (fetch_req_i),
    .depth_nz_i(depth_nz),
    .rdptr_i   (rdptr[MEM_AW-1:0]),
    .rdata_i   (mem_rdata_i),
    .pop_o     (pop),
    .re_o      (mem_re_o),
    .raddr_o   (mem_raddr_o),
    .valid_o   (fetch_valid_o),
    .data_o    (fetch_data_o)
  );

  assign mem_we_o       = op.push;
  assign mem_waddr_o    = base + MEM_AW'({hw_addr_i[OFF_W-1:0], 2'b00});
  assign mem_wdata_o    = hw_data_i;
  assign reg_wr_valid_o = op.fwd;
  assign reg_wr_addr_o  = hw_addr_i;
  assign reg_wr_data_o  = hw_data_i;

  assign busy     = en && depth_nz;
  assign status_o = 32'({{BUSY_W{busy}}, {BUSY_LSB{1'b0}}});

  // R6
  valid_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> $past(depth_nz));
  // R2
  push_not_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !reg_wr_valid_o);
  // R11
  idle_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> status_o == 32'd0);
endmodule

// File: tb/tb_cmdq_mem_ctrl.sv
`timescale 1ns/1ps
module tb_cmdq_mem_ctrl;
  localparam int AW = 20;
  localparam int MAW = 14;

  logic clk = 0, rst_n = 0;
  logic hw_valid = 0, fetch_req = 0;
  logic [AW-1:0] hw_addr = '0;
  logic [31:0] hw_data = '0;
  logic reg_wr_valid, mem_we, mem_re, fetch_valid;
  logic [AW-1:0] reg_wr_addr;
  logic [31:0] reg_wr_data, mem_wdata, fetch_data, status;
  logic [31:0] mem_rdata = '0;
  logic [MAW-1:0] mem_waddr, mem_raddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmdq_mem_ctrl #(.ADDR_W(AW), .MEM_AW(MAW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hw_valid_i(hw_valid), .hw_addr_i(hw_addr), .hw_data_i(hw_data),
    .reg_wr_valid_o(reg_wr_valid), .reg_wr_addr_o(reg_wr_addr), .reg_wr_data_o(reg_wr_data),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .fetch_req_i(fetch_req), .fetch_valid_o(fetch_valid), .fetch_data_o(fetch_data),
    .status_o(status)
  );

  logic [31:0] ram [0:4095];
  always @(posedge clk) begin
    if (mem_we) ram[mem_waddr[13:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_raddr[13:2]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // samples: fwd, we, waddr, wdata
  logic s_fwd, s_we, s_re, s_v;
  logic [MAW-1:0] s_wa, s_ra;
  logic [31:0] s_wd, s_d;
  logic [AW-1:0] s_fa;

  task automatic hwr(input logic [AW-1:0] a, input logic [31:0] d, input bit f);
    @(negedge clk);
    hw_valid = 1; hw_addr = a; hw_data = d; fetch_req = f;
    #1;
    s_fwd = reg_wr_valid; s_fa = reg_wr_addr; s_we = mem_we; s_wa = mem_waddr; s_wd = mem_wdata;
    s_re = mem_re; s_ra = mem_raddr;
    @(negedge clk);
    hw_valid = 0; fetch_req = 0;
    s_v = fetch_valid; s_d = fetch_data;
  endtask

  task automatic fetch();
    @(negedge clk);
    fetch_req = 1;
    #1;
    s_re = mem_re; s_ra = mem_raddr;
    @(negedge clk);
    fetch_req = 0;
    s_v = fetch_valid; s_d = fetch_data;
  endtask

  localparam logic [AW-1:0] A_MODE = 20'h00041, A_BASE = 20'h00078,
                            A_RDP = 20'h00079, A_DEP = 20'h0007A, A_CMD = 20'h80000;

  // {addr, data, expected forward} applied with queue mode on
  localparam logic [52:0] VECS [6] = '{
    {20'h00020, 32'h1111_0020, 1'b1},
    {20'h00005, 32'h2222_0005, 1'b0},
    {20'h00021, 32'h3333_0021, 1'b1},
    {20'h00033, 32'h4444_0033, 1'b0},
    {20'h00060, 32'h5555_0060, 1'b1},
    {20'h000FF, 32'h6666_00FF, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 0 && fetch_valid == 0 && mem_we == 0 && mem_re == 0, "R1 reset outputs", status, 0);
    rst_n = 1;
    fetch();
    chk(!s_re && !s_v, "R1 empty after reset", {s_re, s_v}, 0);

    // R10 / R12 queue mode off: everything forwarded
    hwr(20'h00005, 32'hA5A5_0005, 0);
    chk(s_fwd && s_fa == 20'h00005, "R10 forward while off", s_fa, 20'h00005);
    hwr(20'h80033, 32'hA5A5_0033, 0);
    chk(s_fwd && !s_we && s_fa == 20'h80033, "R12 bit19 write while off", {s_fwd, s_we}, 2'b10);

    // R3 base, R4 rdptr, R12 mode on+store
    hwr(A_BASE, 32'h0003_0001, 0);
    hwr(A_RDP, 32'h0000_1000, 0);
    hwr(A_MODE, 32'h0000_0300, 0);
    chk(!s_fwd, "R10 control write not forwarded", s_fwd, 0);

    // R10 table walk
    for (int i = 0; i < 6; i++) begin
      hwr(VECS[i][52:33], VECS[i][32:1], 0);
      chk(s_fwd == VECS[i][0] && !s_we, "R10 write-through gating", s_fwd, VECS[i][0]);
    end

    // R2 pushes, R3 base placement
    for (int k = 0; k < 3; k++) begin
      hwr(A_CMD | 20'(k), 32'hC0DE_0000 + 32'(k), 0);
      chk(s_we && !s_fwd && s_wa == 14'(32'h1000 + 4 * k) && s_wd == 32'hC0DE_0000 + 32'(k),
          "R2 push address/data (R3 base)", s_wa, 32'h1000 + 4 * k);
    end
    chk(status == 32'h380, "R11 busy with words", status, 32'h380);

    // R5 in-order fetch
    for (int k = 0; k < 3; k++) begin
      fetch();
      chk(s_re && s_ra == 14'(32'h1000 + 4 * k) && s_v && s_d == 32'hC0DE_0000 + 32'(k),
          "R5 fetch order", s_d, 32'hC0DE_0000 + 32'(k));
    end
    fetch();
    chk(!s_re && !s_v, "R6 empty fetch stalls", {s_re, s_v}, 0);
    chk(status == 0, "R11 idle when empty", status, 0);

    // R2 address truncation, R4 rdptr load masked on read side
    hwr(A_CMD | 20'h0FFFF, 32'hDEAD_0007, 0);
    chk(s_we && s_wa == 14'h0FFC, "R2 address truncation", s_wa, 32'h0FFC);
    hwr(A_RDP, 32'h0000_4FFC, 0);
    fetch();
    chk(s_ra == 14'h0FFC && s_v && s_d == 32'hDEAD_0007, "R4 rdptr load", s_d, 32'hDEAD_0007);

    // R7 simultaneous push and fetch
    hwr(A_CMD | 20'h00003, 32'h7, 0);
    hwr(A_CMD | 20'h00004, 32'h8, 1);
    chk(s_we && s_v, "R7 push+fetch both act", {s_we, s_v}, 2'b11);
    fetch();
    chk(s_v, "R7 one word remains", s_v, 1);
    fetch();
    chk(!s_v, "R7 no extra word", s_v, 0);

    // R8 saturation
    hwr(A_DEP, 32'h0000_FFFF, 0);
    chk(status == 32'h380, "R4 depth load", status, 32'h380);
    hwr(A_CMD | 20'h00010, 32'h9, 0);
    chk(status == 32'h380, "R8 saturate at max", status, 32'h380);
    hwr(A_DEP, 32'h0, 0);
    chk(status == 0, "R4 depth cleared", status, 0);

    // R9 depth load beats fetch
    hwr(A_CMD | 20'h00020, 32'hA, 0);
    hwr(A_CMD | 20'h00021, 32'hB, 0);
    hwr(A_DEP, 32'd5, 1);
    chk(s_v, "R9 fetch with depth load", s_v, 1);
    nv = 0;
    for (int k = 0; k < 6; k++) begin
      fetch();
      if (s_v) nv++;
    end
    chk(nv == 5, "R9 depth load priority", nv, 5);

    // R9 rdptr load beats fetch increment
    hwr(A_DEP, 32'd2, 0);
    hwr(A_RDP, 32'h0000_2000, 1);
    fetch();
    chk(s_re && s_ra == 14'h2000, "R9 rdptr load priority", s_ra, 32'h2000);

    // R4 depth uses only low 16 bits
    hwr(A_DEP, 32'h0001_0000, 0);
    chk(status == 0, "R4 depth low half", status, 0);
    fetch();
    chk(!s_v, "R6 no word after zero load", s_v, 0);

    // R12 queue on, store off: bit19 writes are ordinary
    hwr(A_MODE, 32'h0000_0100, 0);
    hwr(20'h80020, 32'h1234, 0);
    chk(s_fwd && !s_we, "R12 bit19 through write-through", {s_fwd, s_we}, 2'b10);
    hwr(20'h80005, 32'h5678, 0);
    chk(!s_fwd && !s_we, "R12 bit19 dropped", {s_fwd, s_we}, 0);

    // R11 busy needs queue mode
    hwr(A_DEP, 32'd3, 0);
    chk(status == 32'h380, "R11 busy with mode on", status, 32'h380);
    hwr(A_MODE, 32'h0, 0);
    chk(status == 0, "R11 not busy with mode off", status, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule